// File: doc/BRIEF.md
# Caption Line Waveform Sequencer

This block builds the sample stream for one video line that carries two caption characters. It runs on the pixel-rate sample clock. A one-cycle trigger starts a line, and at that moment the block latches two 7-bit characters and appends an odd-parity bit to each. After a programmable delay from the trigger, it plays a sinusoidal run-in of seven cycles. It then holds blanking level for two bit times, sends one high start bit, and finally sends the sixteen data bits, with each character's low bit first and its parity bit last.

The block's output is an unsigned amplitude code for the downstream DAC path. Bit timing comes from a phase accumulator. A bit spans the cycles between two accumulator wraps, so a rate ratio that is not an integer does not build up error across the line. The same accumulator phase addresses a quarter-wave table that shapes the run-in. Troughs of the run-in land on the blanking code and crests land on the data-high code. A busy flag marks the whole sequence, and the block ignores triggers while the flag is high.

Top module: `cc_line_seq`

## Requirements
- R1: While reset is asserted, and after it is released until a trigger, `level` equals BLANK_LVL and `busy` is 0. A reset in the middle of a line returns the block to this idle state.
- R2: A trigger (`line_go` high at a clock edge while idle) sets `busy` after that edge. `level` stays at BLANK_LVL for DELAY_SAMPLES+1 samples after the trigger edge.
- R3: The run-in is exactly seven sine cycles, each one bit period long. At phase 0 of each cycle `level` equals BLANK_LVL, at phase 1/2 it equals HIGH_LVL, and at phases 1/4 and 3/4 it equals the midpoint (BLANK_LVL+HIGH_LVL)/2.
- R4: After the run-in, `level` holds BLANK_LVL for two bit periods.
- R5: One start bit at HIGH_LVL follows for one bit period.
- R6: Sixteen data bits follow. The order is `char0` bits 0..6, then odd parity of `char0`, then `char1` bits 0..6, then odd parity of `char1`. A 1 bit is sent as HIGH_LVL and a 0 bit as BLANK_LVL. Odd parity means the eight bits of each byte hold an odd number of ones.
- R7: A trigger that arrives while `busy` is high has no effect on the waveform or on the time at which `busy` falls.
- R8: The characters are latched at the accepted trigger. Later changes on `char0`/`char1` do not alter the line in progress.
- R9: A bit period is the span between accumulator wraps. The accumulator is ACC_W bits wide and advances by PHASE_INC per sample, so with PHASE_INC = 2^ACC_W/16 every bit lasts exactly 16 samples.
- R10: `busy` falls on the edge that ends the last data bit, which is the (DELAY_SAMPLES+26·bit-samples)-th edge after the trigger. A trigger on the very next edge is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_go | input | 1 | Line-start trigger, sampled each edge |
| char0 | input | 7 | First character, sent first |
| char1 | input | 7 | Second character |
| busy | output | 1 | High from the accepted trigger until the last data bit ends |
| level | output | OUT_W | Registered amplitude code |

## Verification
Two events can meet in the same cycle: the end of the last data bit, which frees the sequencer, and a new trigger. The bench holds `line_go` high across the edge that ends the final bit and across the edge after it. It then judges the result from the exact sample at which `busy` drops and rises again: the edge still inside the line must be ignored and the first idle edge must start a fresh line. A second case drives a trigger and changed characters in the middle of a line. The bench then compares every mid-bit sample against the characters that were latched originally.

// File: rtl/cc_pkg.sv
package cc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DELAY,
    ST_RUNIN,
    ST_HOLD,
    ST_START,
    ST_DATA
  } seq_state_e;

  localparam int unsigned CHAR_W       = 7;
  localparam int unsigned RUNIN_CYCLES = 7;
  localparam int unsigned HOLD_BITS    = 2;
  localparam int unsigned WORD_BITS    = 2 * (CHAR_W + 1);

  function automatic logic odd_par(input logic [CHAR_W-1:0] c);
    return ~^c;
  endfunction

endpackage

// File: rtl/cc_phase_acc.sv
module cc_phase_acc #(
  parameter int unsigned ACC_W     = 24,
  parameter int unsigned PHASE_INC = 625714,
  parameter int unsigned PH_W      = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            en,
  output logic            tick,
  output logic [PH_W-1:0] ph
);

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum  = {1'b0, acc_q} + (ACC_W+1)'(PHASE_INC);
    tick = en & sum[ACC_W];
  end

  always_comb begin
    acc_d = acc_q;
    if (clr)     acc_d = '0;
    else if (en) acc_d = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign ph = acc_q[ACC_W-1 -: PH_W];

  generate
    if (PHASE_INC < (1 << (ACC_W-1))) begin : g_sparse
      AST_TICK_SPARSE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick) |=> !tick); // R9
    end
  endgenerate

endmodule

// File: rtl/cc_wave_lut.sv
module cc_wave_lut #(
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned QW        = 8,
  parameter int unsigned OUT_W     = 8,
  parameter int unsigned BLANK_LVL = 60,
  parameter int unsigned HIGH_LVL  = 160
) (
  input  logic [IDX_W+1:0] ph_i,
  output logic [OUT_W-1:0] level_o
);

  localparam int unsigned N   = 1 << IDX_W;
  localparam int unsigned AMP = (HIGH_LVL - BLANK_LVL) / 2;
  localparam int unsigned MID = BLANK_LVL + AMP;
  localparam int unsigned PW  = OUT_W + QW + 2;

  function automatic int unsigned qval(input int unsigned k);
    return (k * (2*N - k) * (1 << QW)) / (N * N);
  endfunction

  logic [QW:0] tbl [0:N];

  generate
    for (genvar k = 0; k <= N; k++) begin : g_tbl
      assign tbl[k] = (QW+1)'(qval(k));
    end
  endgenerate

  logic [IDX_W+1:0] phs;
  logic [1:0]       quad;
  logic [IDX_W:0]   idx, midx;
  logic [QW:0]      mag;
  logic [PW-1:0]    prod;
  logic [OUT_W-1:0] scaled;

  always_comb begin
    phs     = ph_i + (IDX_W+2)'(3 << IDX_W);
    quad    = phs[IDX_W+1:IDX_W];
    idx     = {1'b0, phs[IDX_W-1:0]};
    midx    = (IDX_W+1)'(N) - idx;
    mag     = quad[0] ? tbl[midx] : tbl[idx];
    prod    = PW'(AMP) * PW'(mag);
    scaled  = OUT_W'(prod >> QW);
    level_o = quad[1] ? (OUT_W'(MID) - scaled) : (OUT_W'(MID) + scaled);
  end

endmodule

// File: rtl/cc_seq_fsm.sv
module cc_seq_fsm
  import cc_pkg::*;
#(
  parameter int unsigned DELAY_SAMPLES = 142
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [CHAR_W-1:0] char0,
  input  logic [CHAR_W-1:0] char1,
  input  logic              tick,
  output seq_state_e        state,
  output logic              acc_clr,
  output logic              acc_en,
  output logic              data_bit,
  output logic              busy
);

  localparam int unsigned DLY_W = $clog2(DELAY_SAMPLES + 1);
  localparam int unsigned BIT_W = $clog2(WORD_BITS);

  seq_state_e           state_q, state_d;
  logic [DLY_W-1:0]     dly_q, dly_d;
  logic [BIT_W-1:0]     bit_q, bit_d;
  logic [WORD_BITS-1:0] shr_q, shr_d;

  always_comb begin
    state_d = state_q;
    dly_d   = dly_q;
    bit_d   = bit_q;
    shr_d   = shr_q;
    acc_clr = 1'b0;
    unique case (state_q)
      ST_IDLE: if (go) begin
        state_d = ST_DELAY;
        dly_d   = '0;
        shr_d   = {odd_par(char1), char1, odd_par(char0), char0};
      end
      ST_DELAY: begin
        if (dly_q == DLY_W'(DELAY_SAMPLES - 1)) begin
          state_d = ST_RUNIN;
          acc_clr = 1'b1;
          bit_d   = '0;
        end else begin
          dly_d = dly_q + 1'b1;
        end
      end
      ST_RUNIN: if (tick) begin
        if (bit_q == BIT_W'(RUNIN_CYCLES - 1)) begin
          state_d = ST_HOLD;
          bit_d   = '0;
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end
      ST_HOLD: if (tick) begin
        if (bit_q == BIT_W'(HOLD_BITS - 1)) begin
          state_d = ST_START;
          bit_d   = '0;
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end
      ST_START: if (tick) begin
        state_d = ST_DATA;
        bit_d   = '0;
      end
      ST_DATA: if (tick) begin
        shr_d = shr_q >> 1;
        if (bit_q == BIT_W'(WORD_BITS - 1)) state_d = ST_IDLE;
        else                                bit_d   = bit_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dly_q   <= '0;
      bit_q   <= '0;
      shr_q   <= '0;
    end else begin
      state_q <= state_d;
      dly_q   <= dly_d;
      bit_q   <= bit_d;
      shr_q   <= shr_d;
    end
  end

  assign state    = state_q;
  assign acc_en   = (state_q inside {ST_RUNIN, ST_HOLD, ST_START, ST_DATA});
  assign data_bit = shr_q[0];
  assign busy     = (state_q != ST_IDLE);

  AST_RUNIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUNIN) |-> (bit_q < BIT_W'(RUNIN_CYCLES))); // R3
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q inside {ST_RUNIN, ST_HOLD, ST_START, ST_DATA}) |=> (state_q != ST_DELAY)); // R7
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q inside {ST_DELAY, ST_RUNIN, ST_HOLD, ST_START}) |=> (shr_q == $past(shr_q))); // R8
  AST_BUSY_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> busy); // R10

endmodule

// File: rtl/cc_line_seq.sv
module cc_line_seq
  import cc_pkg::*;
#(
  parameter int unsigned ACC_W         = 24,
  parameter int unsigned PHASE_INC     = 625714,
  parameter int unsigned DELAY_SAMPLES = 142,
  parameter int unsigned IDX_W         = 4,
  parameter int unsigned QW            = 8,
  parameter int unsigned OUT_W         = 8,
  parameter int unsigned BLANK_LVL     = 60,
  parameter int unsigned HIGH_LVL      = 160
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_go,
  input  logic [6:0]       char0,
  input  logic [6:0]       char1,
  output logic             busy,
  output logic [OUT_W-1:0] level
);

  localparam int unsigned PH_W = IDX_W + 2;

  logic [1:0] rst_sync;
  logic       rst_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_q = rst_sync[1];

  seq_state_e       state;
  logic             acc_clr, acc_en, tick, data_bit;
  logic [PH_W-1:0]  ph;
  logic [OUT_W-1:0] sine_lvl, level_d, level_q;

  cc_phase_acc #(.ACC_W(ACC_W), .PHASE_INC(PHASE_INC), .PH_W(PH_W)) u_acc (
    .clk(clk), .rst_n(rst_n_q), .clr(acc_clr), .en(acc_en), .tick(tick), .ph(ph)
  );

  cc_seq_fsm #(.DELAY_SAMPLES(DELAY_SAMPLES)) u_fsm (
    .clk(clk), .rst_n(rst_n_q), .go(line_go), .char0(char0), .char1(char1),
    .tick(tick), .state(state), .acc_clr(acc_clr), .acc_en(acc_en),
    .data_bit(data_bit), .busy(busy)
  );

  cc_wave_lut #(.IDX_W(IDX_W), .QW(QW), .OUT_W(OUT_W),
                .BLANK_LVL(BLANK_LVL), .HIGH_LVL(HIGH_LVL)) u_lut (
    .ph_i(ph), .level_o(sine_lvl)
  );

  always_comb begin
    unique case (state)
      ST_RUNIN: level_d = sine_lvl;
      ST_START: level_d = OUT_W'(HIGH_LVL);
      ST_DATA:  level_d = data_bit ? OUT_W'(HIGH_LVL) : OUT_W'(BLANK_LVL);
      default:  level_d = OUT_W'(BLANK_LVL);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) level_q <= OUT_W'(BLANK_LVL);
    else          level_q <= level_d;
  end

  assign level = level_q;

  AST_DELAY_QUIET: assert property (@(posedge clk) disable iff (!rst_n_q)
    (state inside {ST_IDLE, ST_DELAY, ST_HOLD}) |=> (level == OUT_W'(BLANK_LVL))); // R2
  AST_RUNIN_SPAN: assert property (@(posedge clk) disable iff (!rst_n_q)
    (state == ST_RUNIN) |=> (level >= OUT_W'(BLANK_LVL) && level <= OUT_W'(HIGH_LVL))); // R3
  AST_DATA_TWO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n_q)
    (state == ST_DATA) |=> (level == OUT_W'(BLANK_LVL) || level == OUT_W'(HIGH_LVL))); // R6
  AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n_q)
    (state == ST_START) |=> (level == OUT_W'(HIGH_LVL))); // R5

endmodule

// File: tb/tb_cc_line_seq.sv
module tb_cc_line_seq;

  localparam int D     = 20;
  localparam int SPB   = 16;
  localparam int BLANK = 60;
  localparam int HIGH  = 160;
  localparam int MIDL  = 110;
  localparam int LINE  = 26 * SPB;
  localparam int LAST  = D + LINE + 6;

  logic       clk, rst_n, line_go, busy;
  logic [6:0] char0, char1;
  logic [7:0] level;

  int errors = 0;
  int checks = 0;
  int lv [0:LAST];
  bit bz [0:LAST];

  cc_line_seq #(.ACC_W(24), .PHASE_INC(1 << 20), .DELAY_SAMPLES(D), .IDX_W(4),
                .QW(8), .OUT_W(8), .BLANK_LVL(BLANK), .HIGH_LVL(HIGH)) dut (
    .clk(clk), .rst_n(rst_n), .line_go(line_go), .char0(char0), .char1(char1),
    .busy(busy), .level(level)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_bit(input int j, input logic [6:0] c0, input logic [6:0] c1);
    if (j < 7)  return c0[j];
    if (j == 7) return ~^c0;
    if (j < 15) return c1[j-8];
    return ~^c1;
  endfunction

  // Level after edge D+1+s is the value for line sample s.
  function automatic int at(input int s);
    return lv[D + 1 + s];
  endfunction

  task automatic run_line(input logic [6:0] c0, input logic [6:0] c1,
                          input int retrig_at, input bit hold_go);
    @(negedge clk);
    char0 = c0; char1 = c1; line_go = 1'b1;
    @(posedge clk);
    @(negedge clk);
    lv[0] = level; bz[0] = busy;
    line_go = 1'b0;
    for (int i = 0; i < LAST; i++) begin
      line_go = (i == retrig_at) || (hold_go && i >= D + LINE - 1);
      if (i == retrig_at) begin char0 = ~c0; char1 = ~c1; end
      @(posedge clk);
      @(negedge clk);
      lv[i+1] = level; bz[i+1] = busy;
    end
    line_go = 1'b0;
  endtask

  task automatic check_line(input logic [6:0] c0, input logic [6:0] c1, input bit hold_go);
    bit ok;
    int bad;
    ok = 1; bad = 0;
    for (int i = 0; i < D + LINE; i++) if (!bz[i]) begin ok = 0; bad = i; end
    check(ok, "R2 busy held during line", bad, -1);
    ok = 1;
    for (int i = 0; i <= D; i++) if (lv[i] != BLANK) begin ok = 0; bad = lv[i]; end
    check(ok, "R2 blank during delay", bad, BLANK);
    for (int b = 0; b < 7; b++) begin
      check(at(16*b) == BLANK,    "R3 run-in trough", at(16*b), BLANK);
      check(at(16*b+4) == MIDL,   "R3 run-in rising mid", at(16*b+4), MIDL);
      check(at(16*b+8) == HIGH,   "R3 run-in crest", at(16*b+8), HIGH);
      check(at(16*b+12) == MIDL,  "R3 run-in falling mid", at(16*b+12), MIDL);
    end
    check(at(7*SPB+8) == BLANK, "R4 hold bit 1 (R9 timing)", at(7*SPB+8), BLANK);
    check(at(8*SPB+8) == BLANK, "R4 hold bit 2", at(8*SPB+8), BLANK);
    check(at(9*SPB) == HIGH && at(9*SPB+15) == HIGH, "R5 start bit", at(9*SPB+8), HIGH);
    for (int j = 0; j < 16; j++) begin
      int e;
      e = exp_bit(j, c0, c1) ? HIGH : BLANK;
      check(at((10+j)*SPB+8) == e, $sformatf("R6 data bit %0d", j), at((10+j)*SPB+8), e);
    end
    check(bz[D+LINE] == 1'b0, "R10 busy falls after last bit", bz[D+LINE], 0);
    if (hold_go) check(bz[D+LINE+1] == 1'b1, "R10 trigger on first idle edge", bz[D+LINE+1], 1);
    else         check(lv[D+LINE+1] == BLANK, "R10 idle level after line", lv[D+LINE+1], BLANK);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 1000 && busy; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; line_go = 1'b0; char0 = '0; char1 = '0;
    repeat (3) @(negedge clk);
    check(level == BLANK, "R1 level in reset", level, BLANK);
    check(busy == 1'b0, "R1 busy in reset", busy, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(level == BLANK && busy == 1'b0, "R1 idle after release", level, BLANK);
  endtask

  task automatic t_basic();
    run_line(7'h14, 7'h7F, -1, 1'b0);
    check_line(7'h14, 7'h7F, 1'b0);
  endtask

  task automatic t_null();
    run_line(7'h00, 7'h00, -1, 1'b0);
    check_line(7'h00, 7'h00, 1'b0);
  endtask

  task automatic t_retrigger();
    // R7 R8: trigger and new characters mid-line
    run_line(7'h35, 7'h4A, D + 150, 1'b0);
    check_line(7'h35, 7'h4A, 1'b0);
    wait_idle();
  endtask

  task automatic t_back_to_back();
    run_line(7'h5A, 7'h21, -1, 1'b1);
    check_line(7'h5A, 7'h21, 1'b1);
    wait_idle();
  endtask

  task automatic t_mid_reset();
    run_line(7'h11, 7'h22, -1, 1'b0);
    @(negedge clk); line_go = 1'b1;
    repeat (D + 40) @(negedge clk);
    line_go = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && level == BLANK, "R1 mid-line reset", busy, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 1'b0 && level == BLANK, "R1 idle after mid-line reset", level, BLANK);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_null();
    t_retrigger();
    t_back_to_back();
    t_mid_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule